// File: doc/BRIEF.md
# Datapath Function Unit

This block is the combinational heart of a simple processor datapath. It takes two operands, A and B, and a 4-bit function select code, and returns a result word together with four status flags: overflow (V), carry (C), negative (N) and zero (Z). The result comes from one of three circuits. An adder forms A plus a chosen B-side value plus a carry-in. A bitwise unit combines A and B. A one-position shifter moves B. A final multiplexer picks the shifter output or the adder/logic output.

The select code is not decoded through a lookup table. Its bits are wired straight into the sub-circuits. The least significant select bit is the adder carry-in and is also the low select of the logic unit. The next bit serves as both the low B-side select of the adder and the high select of the logic unit. The most significant bit chooses logic over arithmetic. The shifter output is taken when the top two bits are both set. The word width is a parameter, with a default of 16 bits. A second parameter chooses between an explicit ripple-carry adder and a behavioural adder.

Top module: `fu_core`

## Requirements
- R1: For select codes 0000 through 0111, F equals A + Y + fs[0] modulo 2^WIDTH. Y is chosen by {fs[2],fs[1]}: 00 gives zero, 01 gives B, 10 gives the bitwise inverse of B and 11 gives all ones. The resulting operations are A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A.
- R2: Code 1000 gives A AND B. Code 1001 gives A OR B. Code 1010 gives A XOR B. Code 1011 gives the bitwise inverse of A.
- R3: Code 1100 passes B. Code 1101 shifts B right by one bit and places a zero in the MSB. Code 1110 shifts B left by one bit and places a zero in the LSB.
- R4: Code 1111 gives F equal to B, with C and V both 0.
- R5: Z is 1 exactly when every bit of F is 0.
- R6: N equals the MSB of F.
- R7: For codes with fs[3]=0, C is the carry out of the MSB of the A + Y + fs[0] sum. For codes with fs[3]=1, C is 0.
- R8: For codes with fs[3]=0, V is 1 exactly when A and Y have the same sign bit and the MSB of F differs from it. This is the case where the carries into and out of the MSB differ. For codes with fs[3]=1, V is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fs | input | 4 | Function select code |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| f | output | WIDTH | Result word |
| v | output | 1 | Signed overflow flag |
| c | output | 1 | Carry-out flag |
| n | output | 1 | Negative flag (MSB of result) |
| z | output | 1 | Zero flag |

## Verification
The block holds no state, so any wiring fault appears on F or the flags for the same input vector that triggers it. There is no delay to wait out. A mis-wired select bit swaps two operations. It is caught whenever those two operations give different results for the operands applied. A broken carry chain first shows up at carry-propagating operands such as all ones plus one, or at the signed boundaries 0x7FFF and 0x8000. A flag that is not cleared for logic and shift codes appears as a stray C or V on any vector that would have carried in the adder. The directed corner vectors target these cases. The random vectors cover every code many times over.

// File: rtl/fu_pkg.sv
package fu_pkg;
   typedef enum logic [3:0] {
      FS_PASS_A  = 4'b0000,
      FS_INC     = 4'b0001,
      FS_ADD     = 4'b0010,
      FS_ADD_C   = 4'b0011,
      FS_ADD_NB  = 4'b0100,
      FS_SUB     = 4'b0101,
      FS_DEC     = 4'b0110,
      FS_PASS_A2 = 4'b0111,
      FS_AND     = 4'b1000,
      FS_OR      = 4'b1001,
      FS_XOR     = 4'b1010,
      FS_NOT_A   = 4'b1011,
      FS_PASS_B  = 4'b1100,
      FS_SHR     = 4'b1101,
      FS_SHL     = 4'b1110,
      FS_SPARE   = 4'b1111
   } fs_code_e;

   // B-side selection of the adder, driven by {fs[2], fs[1]}
   localparam logic [1:0] YSEL_ZERO = 2'b00;
   localparam logic [1:0] YSEL_B    = 2'b01;
   localparam logic [1:0] YSEL_NB   = 2'b10;
   localparam logic [1:0] YSEL_ONES = 2'b11;
endpackage

// File: rtl/fu_arith.sv
module fu_arith #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   ysel,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         c_msb
);
   import fu_pkg::*;

   logic [W-1:0] y;

   always_comb begin
      unique case (ysel)
         YSEL_ZERO: y = '0;
         YSEL_B:    y = b;
         YSEL_NB:   y = ~b;
         default:   y = '1;
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (a[i] & y[i]) | (cy[i] & (a[i] ^ y[i]));
         end
         assign cout  = cy[W];
         assign c_msb = cy[W-1];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide  = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin};
         assign sum   = wide[W-1:0];
         assign cout  = wide[W];
         assign c_msb = wide[W-1] ^ a[W-1] ^ y[W-1];
      end
   endgenerate
endmodule

// File: rtl/fu_logic.sv
module fu_logic #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] g
);
   always_comb begin
      unique case (sel)
         2'b00:   g = a & b;
         2'b01:   g = a | b;
         2'b10:   g = a ^ b;
         default: g = ~a;
      endcase
   end
endmodule

// File: rtl/fu_shift.sv
module fu_shift #(
   parameter int W = 16
) (
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] h
);
   always_comb begin
      unique case (sel)
         2'b01:   h = {1'b0, b[W-1:1]};
         2'b10:   h = {b[W-2:0], 1'b0};
         default: h = b;
      endcase
   end
endmodule

// File: rtl/fu_core.sv
module fu_core #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [3:0]       fs,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] f,
   output logic             v,
   output logic             c,
   output logic             n,
   output logic             z
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fu_core: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sum_w, log_w, sh_w, g_w;
   logic             cout_w, cmsb_w, is_arith, use_shift;

   fu_arith #(.W(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .a(a), .b(b), .ysel(fs[2:1]), .cin(fs[0]),
      .sum(sum_w), .cout(cout_w), .c_msb(cmsb_w)
   );

   fu_logic #(.W(WIDTH)) u_logic (
      .a(a), .b(b), .sel(fs[1:0]), .g(log_w)
   );

   fu_shift #(.W(WIDTH)) u_shift (
      .b(b), .sel(fs[1:0]), .h(sh_w)
   );

   assign is_arith  = ~fs[3];
   assign use_shift = fs[3] & fs[2];
   assign g_w       = is_arith ? sum_w : log_w;
   assign f         = use_shift ? sh_w : g_w;

   assign c = is_arith & cout_w;
   assign v = is_arith & (cout_w ^ cmsb_w);
   assign n = f[MSB];
   assign z = ~|f;
endmodule

// File: rtl/fu_core_chk.sv
module fu_core_chk #(
   parameter int W = 16
) (
   input logic [3:0]   fs,
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic [W-1:0] f,
   input logic         v,
   input logic         c,
   input logic         z
);
   logic [W-1:0] inc_a, sub_ab;
   assign inc_a  = W'(a + 1'b1);
   assign sub_ab = W'(a - b);

   always_comb begin
      if (fs == 4'b0001)
         a_r1_increment: assert (f == inc_a);
      if (fs == 4'b0101)
         a_r1_subtract: assert (f == sub_ab);
      if (fs == 4'b1000)
         a_r2_and_bits: assert (f == (a & b));
      if (fs == 4'b1101)
         a_r3_shift_right: assert (f == {1'b0, b[W-1:1]});
      if (fs == 4'b1110)
         a_r3_shift_left: assert (f == {b[W-2:0], 1'b0});
      if (fs == 4'b1111)
         a_r4_spare_pass_b: assert (f == b && !c && !v);
      if (fs == 4'b0101 && a == b)
         a_r5_equal_sub_zero: assert (z);
      if (fs[3])
         a_r7_no_carry: assert (!c);
      if (fs[3])
         a_r8_no_overflow: assert (!v);
   end
endmodule

bind fu_core fu_core_chk #(.W(WIDTH)) u_chk (
   .fs(fs), .a(a), .b(b), .f(f), .v(v), .c(c), .z(z)
);

// File: tb/fu_core_tb.sv
module fu_core_tb;
   localparam int  W          = 16;
   localparam time CLK_PERIOD = 10ns;
   localparam int  N_RANDOM   = 3000;
   localparam int  WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [3:0]   fs;
   logic [W-1:0] a, b, f;
   logic         v, c, n, z;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   fu_core #(.WIDTH(W)) u_dut (
      .fs(fs), .a(a), .b(b), .f(f), .v(v), .c(c), .n(n), .z(z)
   );

   typedef struct packed {
      logic         v, c, n, z;
      logic [W-1:0] f;
   } exp_t;

   function automatic exp_t model(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
      exp_t e;
      logic [W-1:0] yy;
      logic [W:0]   wide;
      e = '0;
      if (!s[3]) begin
         case (s[2:1])
            2'b00: yy = '0;
            2'b01: yy = y;
            2'b10: yy = ~y;
            default: yy = '1;
         endcase
         wide = {1'b0, x} + {1'b0, yy} + (W+1)'(s[0]);
         e.f = wide[W-1:0];
         e.c = wide[W];
         e.v = (x[W-1] == yy[W-1]) && (wide[W-1] != x[W-1]);
      end else begin
         case (s[2:0])
            3'b000: e.f = x & y;
            3'b001: e.f = x | y;
            3'b010: e.f = x ^ y;
            3'b011: e.f = ~x;
            3'b101: e.f = y >> 1;
            3'b110: e.f = y << 1;
            default: e.f = y;
         endcase
      end
      e.n = e.f[W-1];
      e.z = (e.f == '0);
      return e;
   endfunction

   function automatic string f_tag(input logic [3:0] s);
      if (!s[3])       return "R1";
      if (!s[2])       return "R2";
      if (s == 4'hF)   return "R4";
      return "R3";
   endfunction

   task automatic cmp(input string tag, input logic [W-1:0] got, input logic [W-1:0] expv,
                      input logic [3:0] s);
      n_chk++;
      if (got !== expv) begin
         n_bad++;
         $display("FAIL %s fs=%b a=%h b=%h actual=%h expected=%h", tag, s, a, b, got, expv);
      end
   endtask

   task automatic apply(input logic [3:0] s, input logic [W-1:0] x, input logic [W-1:0] y);
      exp_t e;
      @(posedge clk);
      fs = s; a = x; b = y;
      @(negedge clk);
      e = model(s, x, y);
      cmp(f_tag(s), f, e.f, s);
      cmp("R5", W'(z), W'(e.z), s);
      cmp("R6", W'(n), W'(e.n), s);
      cmp(s[3] ? (s == 4'hF ? "R4" : "R7") : "R7", W'(c), W'(e.c), s);
      cmp(s[3] ? (s == 4'hF ? "R4" : "R8") : "R8", W'(v), W'(e.v), s);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int unused_seed;
      fs = '0; a = '0; b = '0;
      unused_seed = $urandom(32'h5EED_1234);
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // Initial state: all-zero inputs give zero result, Z set (R5, R1)
      @(negedge clk);
      cmp("R5", W'(z), W'(1'b1), 4'h0);
      cmp("R1", f, '0, 4'h0);

      // R1 every arithmetic code on fixed operands
      for (int k = 0; k < 8; k++) apply(4'(k), 16'h1234, 16'h0F0F);
      // R7 carry out of all-ones plus one
      apply(4'b0001, 16'hFFFF, 16'h0000);
      // R8 positive overflow on increment
      apply(4'b0001, 16'h7FFF, 16'h0000);
      // R8 negative overflow on decrement
      apply(4'b0110, 16'h8000, 16'h0000);
      // R8 subtract overflow
      apply(4'b0101, 16'h8000, 16'h0001);
      // R5 equal operands subtract to zero, R7 borrow-free carry set
      apply(4'b0101, 16'hA5A5, 16'hA5A5);
      // R7 pass-A code 0111 always carries
      apply(4'b0111, 16'h0000, 16'hFFFF);
      // R2 logic codes on patterns
      for (int k = 8; k < 12; k++) apply(4'(k), 16'hFF00, 16'hF0F0);
      // R3 shifts with edge bits set: zero fill
      apply(4'b1101, 16'h0000, 16'h8001);
      apply(4'b1110, 16'h0000, 16'h8001);
      apply(4'b1100, 16'hFFFF, 16'h8000);
      // R4 spare code with operands that would carry in the adder
      apply(4'b1111, 16'hFFFF, 16'hFFFF);
      // R6 negative result from logic
      apply(4'b1011, 16'h0001, 16'h0000);

      // Constrained random: bias operands toward boundary values
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [W-1:0] x, y;
         int pick;
         pick = int'($urandom_range(0, 7));
         x = W'($urandom);
         y = W'($urandom);
         if (pick == 0) x = 16'h7FFF;
         if (pick == 1) x = 16'h8000;
         if (pick == 2) y = x;
         if (pick == 3) x = 16'hFFFF;
         apply(4'($urandom_range(0, 15)), x, y);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule